// File: doc/BRIEF.md
# Register Extend-and-Shift Operand Unit

This combinational unit prepares the second operand of an integer datapath from a register read. It takes the value read from the register file, the index of that register, a 3-bit extend kind and a small left-shift amount. It keeps a low field of the register, shifts zeros in beneath it, and fills the bits above the shifted field with copies of the field's top bit or with zeros. All of this happens within the same cycle. Register index 31 is the zero register and supplies a value of zero.

The datapath width is a parameter and may be 8, 16, 32 or 64 bits. The kept field is clamped so that it never runs past the top of the result once it has been shifted. For this reason the fill is applied to the shifted field, not to the raw register. If the shift amount is larger than the legal maximum, the unit flags the shift as illegal and returns zero. The register-file storage itself is outside the block.

Top module: `ext_shift_unit`

## Requirements
- R1: `ext_kind[2]` selects the fill, with 0 meaning zero-fill and 1 meaning sign-fill. `ext_kind[1:0]` selects the source field size: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64.
- R2: The kept field length is the smaller of the selected source size and `DATA_W - shift_amt`.
- R3: For a legal shift, the lowest `shift_amt` bits of `operand` are zero.
- R4: For a legal shift, `operand[len+shift_amt-1 : shift_amt]` equals the low `len` bits of the source value, where `len` is the kept field length from R2.
- R5: With sign-fill, every bit of `operand` above the shifted field equals `operand[len+shift_amt-1]`. With zero-fill, every such bit is zero.
- R6: When `reg_idx` is 31, the source value is zero whatever `reg_val` holds, so a legal shift gives `operand` = 0.
- R7: A `shift_amt` greater than 4 drives `bad_shift` to 1 and forces `operand` to 0. For a `shift_amt` from 0 to 4, `bad_shift` is 0.
- R8: The unit has no state. `operand` and `bad_shift` follow a change on any input without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_idx | input | 5 | Index of the source register; 31 is the zero register |
| reg_val | input | DATA_W | Value read from the register file for `reg_idx` |
| ext_kind | input | 3 | Fill select in bit 2, field size in bits 1:0 |
| shift_amt | input | 3 | Left shift amount; 0 to 4 are legal |
| operand | output | DATA_W | Prepared operand |
| bad_shift | output | 1 | High when `shift_amt` is above 4 |

## Verification
The bench sweeps all eight extend kinds against all eight shift codes, using a set of register values that includes all-ones, isolated sign bits and pseudo-random words. It runs at a 32-bit width, so the 32- and 64-bit kinds with a nonzero shift take the clamped-length path. A design that clamped before the shift, or did not clamp at all, would fill from the wrong bit: it would produce a set top bit where zero is expected, or the reverse. A design that filled from the register's own top bit instead of the shifted field's top bit would differ on every signed byte or halfword whose field top differs from bit 31. Shift codes 5 to 7 and index 31 with an all-ones register catch an operand that leaks through where zero is expected.

// File: rtl/xs_pkg.sv
package xs_pkg;

   typedef enum logic [1:0] {
      XS_SZ8  = 2'd0,
      XS_SZ16 = 2'd1,
      XS_SZ32 = 2'd2,
      XS_SZ64 = 2'd3
   } xs_size_e;

   typedef struct packed {
      logic     sign_fill;
      xs_size_e size;
   } xs_kind_t;

   function automatic int unsigned xs_size_bits(input xs_size_e s);
      return 32'd8 << s;
   endfunction

endpackage

// File: rtl/xs_src_select.sv
module xs_src_select #(
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned IDX_W    = 5,
   parameter bit          ZERO_REG = 1'b1
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] val,
   output logic [DATA_W-1:0] src
);
   localparam logic [IDX_W-1:0] ZERO_IDX = {IDX_W{1'b1}};

   generate
      if (ZERO_REG) begin : g_zero_reg
         assign src = (idx == ZERO_IDX) ? '0 : val;
      end else begin : g_plain
         assign src = val;
      end
   endgenerate
endmodule

// File: rtl/xs_field_len.sv
module xs_field_len
   import xs_pkg::*;
#(
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned SHIFT_W = 3,
   parameter int unsigned LEN_W   = $clog2(DATA_W) + 1
) (
   input  xs_size_e           size,
   input  logic [SHIFT_W-1:0] shift,
   output logic [LEN_W-1:0]   len
);
   int unsigned want_bits;
   int unsigned room_bits;

   always_comb begin
      want_bits = xs_size_bits(size);
      room_bits = DATA_W - 32'(shift);
      len = (want_bits < room_bits) ? LEN_W'(want_bits) : LEN_W'(room_bits);
   end
endmodule

// File: rtl/xs_shift_extend.sv
module xs_shift_extend #(
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned SHIFT_W = 3,
   parameter int unsigned LEN_W   = $clog2(DATA_W) + 1
) (
   input  logic [DATA_W-1:0]  src,
   input  logic [SHIFT_W-1:0] shift,
   input  logic [LEN_W-1:0]   len,
   input  logic               sign_fill,
   output logic [DATA_W-1:0]  result
);
   localparam int unsigned TOP_W = LEN_W + 1;

   logic [DATA_W-1:0] shifted;
   logic [TOP_W-1:0]  fld_top;
   logic              fill_bit;

   assign shifted  = src << shift;
   assign fld_top  = TOP_W'(len) + TOP_W'(shift);
   assign fill_bit = sign_fill & shifted[fld_top - TOP_W'(1)];

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         assign result[b] = (TOP_W'(b) < fld_top) ? shifted[b] : fill_bit;
      end
   endgenerate
endmodule

// File: rtl/ext_shift_unit.sv
module ext_shift_unit
   import xs_pkg::*;
#(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned SHIFT_W   = 3,
   parameter int unsigned MAX_SHIFT = 4,
   parameter bit          ZERO_REG  = 1'b1
) (
   input  logic [4:0]         reg_idx,
   input  logic [DATA_W-1:0]  reg_val,
   input  logic [2:0]         ext_kind,
   input  logic [SHIFT_W-1:0] shift_amt,
   output logic [DATA_W-1:0]  operand,
   output logic               bad_shift
);
   localparam int unsigned LEN_W = $clog2(DATA_W) + 1;
   localparam int unsigned TOP_W = LEN_W + 1;

   generate
      if (!(DATA_W == 8 || DATA_W == 16 || DATA_W == 32 || DATA_W == 64)) begin : g_bad_width
         $error("ext_shift_unit: DATA_W must be 8, 16, 32 or 64");
      end
      if (MAX_SHIFT >= (1 << SHIFT_W) || MAX_SHIFT >= DATA_W) begin : g_bad_shift
         $error("ext_shift_unit: MAX_SHIFT does not fit SHIFT_W or DATA_W");
      end
   endgenerate

   xs_kind_t          kind;
   logic [DATA_W-1:0] src;
   logic [LEN_W-1:0]  len;
   logic [DATA_W-1:0] shaped;
   logic              legal;

   assign kind  = xs_kind_t'(ext_kind);
   assign legal = (32'(shift_amt) <= MAX_SHIFT);

   xs_src_select #(.DATA_W(DATA_W), .IDX_W(5), .ZERO_REG(ZERO_REG)) u_src (
      .idx (reg_idx),
      .val (reg_val),
      .src (src)
   );

   xs_field_len #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W), .LEN_W(LEN_W)) u_len (
      .size  (kind.size),
      .shift (shift_amt),
      .len   (len)
   );

   xs_shift_extend #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W), .LEN_W(LEN_W)) u_shx (
      .src       (src),
      .shift     (shift_amt),
      .len       (len),
      .sign_fill (kind.sign_fill),
      .result    (shaped)
   );

   assign operand   = legal ? shaped : '0;
   assign bad_shift = ~legal;

   // Checks relating the outputs of the sub-blocks to the top-level ports.
   logic [TOP_W-1:0]  chk_top;
   logic [DATA_W-1:0] chk_low_mask;
   logic [DATA_W-1:0] chk_above;
   logic [DATA_W-1:0] chk_from_msb;

   always_comb begin
      chk_top      = TOP_W'(len) + TOP_W'(shift_amt);
      chk_low_mask = (DATA_W'(1) << shift_amt) - DATA_W'(1);
      chk_above    = operand >> chk_top;
      chk_from_msb = DATA_W'($signed(operand) >>> (chk_top - TOP_W'(1)));
   end

   always_comb begin
      if (bad_shift) begin
         assert_illegal_zero_R7: assert (operand == '0);
      end
      if (legal) begin
         assert_len_clamp_R2: assert ((32'(len) <= DATA_W - 32'(shift_amt)) &&
                                      (32'(len) <= xs_size_bits(kind.size)));
         assert_low_zero_R3: assert ((operand & chk_low_mask) == '0);
         if (!kind.sign_fill) begin
            assert_zero_fill_R5: assert (chk_above == '0);
         end else begin
            assert_sign_fill_R5: assert (chk_from_msb == '0 || chk_from_msb == '1);
         end
         if (ZERO_REG && reg_idx == 5'd31) begin
            assert_zero_reg_R6: assert (operand == '0);
         end
      end
   end
endmodule

// File: tb/ext_shift_unit_tb_top.sv
module ext_shift_unit_tb_top;
   localparam int unsigned W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [4:0]   reg_idx = '0;
   logic [W-1:0] reg_val = '0;
   logic [2:0]   ext_kind = '0;
   logic [2:0]   shift_amt = '0;
   logic [W-1:0] operand;
   logic         bad_shift;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;   // 125 MHz

   ext_shift_unit #(.DATA_W(W)) dut_i (
      .reg_idx   (reg_idx),
      .reg_val   (reg_val),
      .ext_kind  (ext_kind),
      .shift_amt (shift_amt),
      .operand   (operand),
      .bad_shift (bad_shift)
   );

   function automatic logic [W-1:0] model(input int k, input int sh,
                                          input logic [W-1:0] v, input int idx);
      longint unsigned sz, len, f;
      if (sh > 4) return '0;
      if (idx == 31) v = '0;
      sz  = 64'd8 << (k % 4);
      len = (sz < longint'(W - sh)) ? sz : longint'(W - sh);
      f   = longint'(v) & ((64'd1 << len) - 64'd1);
      if (k >= 4 && f[len-1]) f = f - (64'd1 << len);
      return W'(f << sh);
   endfunction

   task automatic check(input string tag, input logic [W-1:0] exp_op, input logic exp_bad);
      checks++;
      if (operand !== exp_op || bad_shift !== exp_bad) begin
         failures++;
         $display("FAIL %s idx=%0d kind=%0d sh=%0d val=%h got=%h/%b exp=%h/%b",
                  tag, reg_idx, ext_kind, shift_amt, reg_val, operand, bad_shift,
                  exp_op, exp_bad);
      end
   endtask

   task automatic apply(input int idx, input int k, input int sh, input logic [W-1:0] v);
      string tag;
      @(negedge clk);
      reg_idx = 5'(idx); ext_kind = 3'(k); shift_amt = 3'(sh); reg_val = v;
      #1;
      if (sh > 4)           tag = "R7";
      else if (idx == 31)   tag = "R6";
      else if (k >= 4)      tag = "R1 R2 R3 R5";
      else                  tag = "R1 R2 R3 R4";
      check(tag, model(k, sh, v, idx), sh > 4);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [W-1:0] vals [24];
      logic [W-1:0] lcg;
      lcg = 32'h1234_5678;
      for (int j = 0; j < 24; j++) begin
         case (j)
            0: vals[j] = 32'h0000_0000;
            1: vals[j] = 32'hFFFF_FFFF;
            2: vals[j] = 32'h8000_0000;
            3: vals[j] = 32'h0000_0080;
            4: vals[j] = 32'h0000_8000;
            5: vals[j] = 32'h4000_007F;
            6: vals[j] = 32'h0800_0000;
            7: vals[j] = 32'h7FFF_FFFF;
            default: begin
               lcg = lcg * 32'd1664525 + 32'd1013904223;
               vals[j] = lcg;
            end
         endcase
      end

      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 idle", '0, 1'b0);

      // Exhaustive kind x shift sweep; clamping at W=32 covers R2.
      for (int k = 0; k < 8; k++)
         for (int sh = 0; sh < 8; sh++)
            for (int j = 0; j < 24; j++)
               apply(5, k, sh, vals[j]);

      // R6: zero register versus neighbouring index.
      for (int k = 0; k < 8; k++)
         for (int sh = 0; sh < 8; sh++) begin
            apply(31, k, sh, 32'hFFFF_FFFF);
            apply(30, k, sh, 32'hFFFF_FFFF);
         end

      // R8: output follows an input change with no clock edge in between.
      @(negedge clk);
      reg_idx = 5'd3; ext_kind = 3'd4; shift_amt = 3'd0; reg_val = 32'h0000_0080;
      #1 check("R8 step1", 32'hFFFF_FF80, 1'b0);
      reg_val = 32'h0000_007F;
      #1 check("R8 step2", 32'h0000_007F, 1'b0);
      shift_amt = 3'd6;
      #1 check("R8 step3", 32'h0000_0000, 1'b1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule